// File: doc/BRIEF.md
# CPU Debug Breakpoint Match Unit

This block sits beside a CPU and watches every completed bus cycle (address, page bits, data and direction) against two programmable comparators. When a programmed condition is met it produces a one-cycle request, either to enter the debug mode or to take a software interrupt. A single control bit selects which. Configuration is loaded through a small register write port. The CPU supplies an instruction-boundary strobe, a tag-execute strobe carrying the address of the instruction about to run, and two status inputs that report debug mode and trace mode.

Two operating modes are offered. In dual-address mode both comparators look at addresses on their own, and data is never examined. In full mode comparator 0 checks the address and the value register of comparator 1 is compared against the bus data. Breakpoints are either forced or tagged. A forced breakpoint arises from a bus cycle, is held pending and is released at the next instruction boundary. A tagged breakpoint fires when the CPU reports that it is about to execute an instruction whose address matches.

Top module: `bkpt_match_unit`

## Requirements
- R1: After reset both request outputs are low and the enable bit is clear. While enable is clear, no bus cycle, boundary or tag strobe produces a request.
- R2: A write with `wr_en` high loads register `wr_sel` and takes effect in the following cycle. The selects are: 0 = control {bit3 action-debug, bit2 tagged, bit1 full mode, bit0 enable}; 1 and 2 = qualifier of comparator 0 and 1 {bit4 page-check, bit3 rw, bit2 rw-enable, bits1:0 byte-select}; 3 and 5 = comparator 0 and 1 value; 4 and 6 = comparator 0 and 1 page.
- R3: In dual-address mode a completed bus cycle whose address matches either comparator sets a forced breakpoint.
- R4: The address byte-select works as follows: 00 compares the whole address, 01 the high byte only and 10 the low byte only. When page-check is 1, the bus page must also equal the comparator page.
- R5: Byte-select 11 is a range match. It hits when comparator 0 value <= address <= comparator 1 value, compared unsigned, and both ends count.
- R6: For forced breakpoints with rw-enable 1, only cycles whose `bus_rd` equals the rw bit match. With rw-enable 0, reads and writes both match.
- R7: A forced match stays pending until an `insn_bnd` cycle, and that cycle may be the matching cycle itself. The request pulses in the cycle after the boundary. Several matches before one boundary give one request, and a boundary with nothing pending gives none.
- R8: In tagged mode, a `tag_exec` cycle whose `tag_addr`/`tag_page` matches gives a request pulse in the next cycle. Bus cycles and boundaries are ignored.
- R9: In full forced mode a hit needs comparator 0 to match the address, comparator 0's rw qualifier to pass, and the data to match comparator 1's value. The data byte-select of comparator 1 is 01 for the high byte, 10 for the low byte and otherwise both bytes. Comparator 1's rw bits are ignored, and its value is not used as an address.
- R10: In full tagged mode only comparator 0's address is compared, and the data is ignored.
- R11: When the action bit is 1, requests appear on `dbg_req`, and when it is 0 they appear on `swi_req`. The two outputs are never high together.
- R12: While `dbg_active` is high no request is produced and any pending forced match is discarded.
- R13: While `trace_active` is high a tagged breakpoint with the debug action is dropped. Tagged software interrupts and forced breakpoints are not affected.
- R14: Clearing enable discards a pending forced match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select |
| wr_data | input | ADDR_W | Register write data |
| bus_valid | input | 1 | Bus cycle completes this clock |
| bus_rd | input | 1 | 1 = read cycle, 0 = write cycle |
| bus_addr | input | ADDR_W | Bus address |
| bus_page | input | PAGE_W | Bus page/expansion bits |
| bus_data | input | ADDR_W | Bus data |
| insn_bnd | input | 1 | Instruction boundary strobe |
| tag_exec | input | 1 | Tagged instruction about to execute |
| tag_addr | input | ADDR_W | Address of that instruction |
| tag_page | input | PAGE_W | Page of that instruction |
| dbg_active | input | 1 | CPU is running in debug mode |
| trace_active | input | 1 | Debug trace mode is on |
| dbg_req | output | 1 | Debug-mode entry request pulse |
| swi_req | output | 1 | Software interrupt request pulse |

## Verification
The internal state that can go wrong here is the pending flag and the configuration registers. A stale pending flag shows up as an extra request, or a missing one, in the cycle after the next boundary strobe. A wrong register bit changes which cycles hit, so the error appears one cycle after the first bus cycle or tag strobe that should, or should not, match. A behavioural model predicts both outputs on every clock, so any such error is reported within one cycle of the boundary or strobe that exposes it.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;

    typedef enum logic [2:0] {
        SEL_CTRL = 3'd0,
        SEL_Q0   = 3'd1,
        SEL_Q1   = 3'd2,
        SEL_V0   = 3'd3,
        SEL_P0   = 3'd4,
        SEL_V1   = 3'd5,
        SEL_P1   = 3'd6,
        SEL_NONE = 3'd7
    } reg_sel_e;

    typedef enum logic [1:0] {
        BS_WHOLE = 2'b00,
        BS_HIGH  = 2'b01,
        BS_LOW   = 2'b10,
        BS_RANGE = 2'b11
    } bytesel_e;

    // bit3 act_dbg, bit2 tag_mode, bit1 full_mode, bit0 enable
    typedef struct packed {
        logic act_dbg;
        logic tag_mode;
        logic full_mode;
        logic enable;
    } ctrl_t;

    // bit4 pg_en, bit3 rw, bit2 rwe, bits1:0 byte select
    typedef struct packed {
        logic     pg_en;
        logic     rw;
        logic     rwe;
        bytesel_e bs;
    } qual_t;

endpackage

// File: rtl/bkpt_cfg_regs.sv
module bkpt_cfg_regs
    import bkpt_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int PAGE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        wr_sel,
    input  logic [ADDR_W-1:0] wr_data,
    output ctrl_t             ctrl_o,
    output qual_t             q0_o,
    output qual_t             q1_o,
    output logic [ADDR_W-1:0] v0_o,
    output logic [ADDR_W-1:0] v1_o,
    output logic [PAGE_W-1:0] p0_o,
    output logic [PAGE_W-1:0] p1_o
);

    typedef struct packed {
        ctrl_t             ctrl;
        qual_t             q0;
        qual_t             q1;
        logic [ADDR_W-1:0] v0;
        logic [ADDR_W-1:0] v1;
        logic [PAGE_W-1:0] p0;
        logic [PAGE_W-1:0] p1;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) begin
            unique case (reg_sel_e'(wr_sel))
                SEL_CTRL: cfg_d.ctrl = ctrl_t'(wr_data[3:0]);
                SEL_Q0:   cfg_d.q0   = qual_t'(wr_data[4:0]);
                SEL_Q1:   cfg_d.q1   = qual_t'(wr_data[4:0]);
                SEL_V0:   cfg_d.v0   = wr_data;
                SEL_V1:   cfg_d.v1   = wr_data;
                SEL_P0:   cfg_d.p0   = wr_data[PAGE_W-1:0];
                SEL_P1:   cfg_d.p1   = wr_data[PAGE_W-1:0];
                default:  cfg_d      = cfg_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign ctrl_o = cfg_q.ctrl;
    assign q0_o   = cfg_q.q0;
    assign q1_o   = cfg_q.q1;
    assign v0_o   = cfg_q.v0;
    assign v1_o   = cfg_q.v1;
    assign p0_o   = cfg_q.p0;
    assign p1_o   = cfg_q.p1;

    assert_ctrl_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 3'd0) |=> (ctrl_o == ctrl_t'($past(wr_data[3:0]))));

    assert_v0_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 3'd3) |=> (v0_o == $past(wr_data)));

    assert_ctrl_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(ctrl_o));

endmodule

// File: rtl/bkpt_addr_cmp.sv
module bkpt_addr_cmp
    import bkpt_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int PAGE_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [PAGE_W-1:0] page,
    input  qual_t             qual,
    input  logic [ADDR_W-1:0] val,
    input  logic [PAGE_W-1:0] vpage,
    input  logic [ADDR_W-1:0] win_lo,
    input  logic [ADDR_W-1:0] win_hi,
    output logic              hit
);

    localparam int HALF = ADDR_W / 2;

    logic addr_ok;
    logic page_ok;

    always_comb begin
        unique case (qual.bs)
            BS_WHOLE: addr_ok = (addr == val);
            BS_HIGH:  addr_ok = (addr[ADDR_W-1:HALF] == val[ADDR_W-1:HALF]);
            BS_LOW:   addr_ok = (addr[HALF-1:0] == val[HALF-1:0]);
            default:  addr_ok = (addr >= win_lo) && (addr <= win_hi);
        endcase
        page_ok = !qual.pg_en || (page == vpage);
        hit     = addr_ok && page_ok;
    end

endmodule

// File: rtl/bkpt_data_cmp.sv
module bkpt_data_cmp
    import bkpt_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] data,
    input  logic [DATA_W-1:0] val,
    input  bytesel_e          bs,
    output logic              hit
);

    localparam int HALF = DATA_W / 2;

    always_comb begin
        unique case (bs)
            BS_HIGH: hit = (data[DATA_W-1:HALF] == val[DATA_W-1:HALF]);
            BS_LOW:  hit = (data[HALF-1:0] == val[HALF-1:0]);
            default: hit = (data == val);
        endcase
    end

endmodule

// File: rtl/bkpt_req_ctrl.sv
module bkpt_req_ctrl
    import bkpt_pkg::*;
#(
    parameter int NCMP = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  ctrl_t           ctrl,
    input  qual_t           q0,
    input  qual_t           q1,
    input  logic            bus_valid,
    input  logic            bus_rd,
    input  logic [NCMP-1:0] bus_hit,
    input  logic [NCMP-1:0] tag_hit,
    input  logic            data_hit,
    input  logic            insn_bnd,
    input  logic            tag_exec,
    input  logic            dbg_active,
    input  logic            trace_active,
    output logic            dbg_req,
    output logic            swi_req
);

    typedef struct packed {
        logic pend;
        logic dbg;
        logic swi;
    } st_t;

    st_t st_d, st_q;

    logic rw0_ok, rw1_ok;
    logic forced_hit, tagged_hit;
    logic blocked, fire_f, fire_t;

    always_comb begin
        rw0_ok = !q0.rwe || (bus_rd == q0.rw);
        rw1_ok = !q1.rwe || (bus_rd == q1.rw);

        if (ctrl.full_mode) begin
            forced_hit = bus_valid && bus_hit[0] && rw0_ok && data_hit;
            tagged_hit = tag_exec && tag_hit[0];
        end else begin
            forced_hit = bus_valid && ((bus_hit[0] && rw0_ok) || (bus_hit[1] && rw1_ok));
            tagged_hit = tag_exec && (|tag_hit);
        end

        blocked = !ctrl.enable || dbg_active;
        fire_f  = !blocked && !ctrl.tag_mode && insn_bnd && (st_q.pend || forced_hit);
        fire_t  = !blocked && ctrl.tag_mode && tagged_hit;

        st_d     = st_q;
        st_d.dbg = ctrl.act_dbg && (fire_f || (fire_t && !trace_active));
        st_d.swi = !ctrl.act_dbg && (fire_f || fire_t);

        if (blocked || ctrl.tag_mode || fire_f) st_d.pend = 1'b0;
        else if (forced_hit)                    st_d.pend = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dbg_req = st_q.dbg;
    assign swi_req = st_q.swi;

    assert_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(dbg_req && swi_req));

    assert_dbg_block_R12: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_active |=> !(dbg_req || swi_req) && !st_q.pend);

    assert_trace_tag_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.tag_mode && trace_active) |=> !dbg_req);

    assert_disable_clear_R14: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl.enable |=> !st_q.pend && !dbg_req && !swi_req);

    assert_need_bnd_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl.tag_mode && !insn_bnd) |=> !(dbg_req || swi_req));

    assert_pend_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.pend && insn_bnd && ctrl.enable && !dbg_active && !ctrl.tag_mode)
            |=> ($countones({dbg_req, swi_req}) == 1));

endmodule

// File: rtl/bkpt_match_unit.sv
module bkpt_match_unit
    import bkpt_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int PAGE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        wr_sel,
    input  logic [ADDR_W-1:0] wr_data,
    input  logic              bus_valid,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [PAGE_W-1:0] bus_page,
    input  logic [ADDR_W-1:0] bus_data,
    input  logic              insn_bnd,
    input  logic              tag_exec,
    input  logic [ADDR_W-1:0] tag_addr,
    input  logic [PAGE_W-1:0] tag_page,
    input  logic              dbg_active,
    input  logic              trace_active,
    output logic              dbg_req,
    output logic              swi_req
);

    localparam int NCMP = 2;
    localparam int NSRC = 2;

    ctrl_t             ctrl;
    qual_t             q0, q1;
    logic [ADDR_W-1:0] v0, v1;
    logic [PAGE_W-1:0] p0, p1;

    qual_t             cq [NCMP];
    logic [ADDR_W-1:0] cv [NCMP];
    logic [PAGE_W-1:0] cp [NCMP];
    logic [ADDR_W-1:0] sa [NSRC];
    logic [PAGE_W-1:0] sp [NSRC];
    logic [NCMP-1:0]   hits [NSRC];
    logic              data_hit;

    bkpt_cfg_regs #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .ctrl_o  (ctrl),
        .q0_o    (q0),
        .q1_o    (q1),
        .v0_o    (v0),
        .v1_o    (v1),
        .p0_o    (p0),
        .p1_o    (p1)
    );

    assign cq[0] = q0;
    assign cq[1] = q1;
    assign cv[0] = v0;
    assign cv[1] = v1;
    assign cp[0] = p0;
    assign cp[1] = p1;
    assign sa[0] = bus_addr;
    assign sa[1] = tag_addr;
    assign sp[0] = bus_page;
    assign sp[1] = tag_page;

    for (genvar s = 0; s < NSRC; s++) begin : g_src
        for (genvar k = 0; k < NCMP; k++) begin : g_cmp
            bkpt_addr_cmp #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_cmp (
                .addr   (sa[s]),
                .page   (sp[s]),
                .qual   (cq[k]),
                .val    (cv[k]),
                .vpage  (cp[k]),
                .win_lo (v0),
                .win_hi (v1),
                .hit    (hits[s][k])
            );
        end
    end

    bkpt_data_cmp #(.DATA_W(ADDR_W)) u_data (
        .data (bus_data),
        .val  (v1),
        .bs   (q1.bs),
        .hit  (data_hit)
    );

    bkpt_req_ctrl #(.NCMP(NCMP)) u_req (
        .clk          (clk),
        .rst_n        (rst_n),
        .ctrl         (ctrl),
        .q0           (q0),
        .q1           (q1),
        .bus_valid    (bus_valid),
        .bus_rd       (bus_rd),
        .bus_hit      (hits[0]),
        .tag_hit      (hits[1]),
        .data_hit     (data_hit),
        .insn_bnd     (insn_bnd),
        .tag_exec     (tag_exec),
        .dbg_active   (dbg_active),
        .trace_active (trace_active),
        .dbg_req      (dbg_req),
        .swi_req      (swi_req)
    );

    assert_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl.enable) |=> !(dbg_req || swi_req));

endmodule

// File: tb/bkpt_match_unit_bench.sv
`timescale 1ns/1ps
module bkpt_match_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_sel = 3'd0;
    logic [15:0] wr_data = 16'h0;
    logic        bus_valid = 1'b0;
    logic        bus_rd = 1'b0;
    logic [15:0] bus_addr = 16'h0;
    logic [7:0]  bus_page = 8'h0;
    logic [15:0] bus_data = 16'h0;
    logic        insn_bnd = 1'b0;
    logic        tag_exec = 1'b0;
    logic [15:0] tag_addr = 16'h0;
    logic [7:0]  tag_page = 8'h0;
    logic        dbg_active = 1'b0;
    logic        trace_active = 1'b0;
    logic        dbg_req, swi_req;

    always #2 clk = ~clk;

    bkpt_match_unit u_bkpt_match_unit (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .bus_valid(bus_valid), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_page(bus_page),
        .bus_data(bus_data), .insn_bnd(insn_bnd), .tag_exec(tag_exec), .tag_addr(tag_addr),
        .tag_page(tag_page), .dbg_active(dbg_active), .trace_active(trace_active),
        .dbg_req(dbg_req), .swi_req(swi_req)
    );

    int    n_tests = 0;
    int    n_fail  = 0;
    int    cnt_dbg = 0;
    int    cnt_swi = 0;
    bit    checking = 0;
    bit    done = 0;
    string phase = "R1";

    // reference model state
    int m_en, m_full, m_tag, m_act;
    int m_bs[2], m_rwe[2], m_rw[2], m_pge[2], m_val[2], m_pg[2];
    int m_pend;
    bit e_dbg = 0, e_swi = 0;

    function automatic bit m_ahit(int k, int a, int p);
        bit ok;
        if (m_bs[k] == 0)      ok = (a == m_val[k]);
        else if (m_bs[k] == 1) ok = ((a / 256) == (m_val[k] / 256));
        else if (m_bs[k] == 2) ok = ((a % 256) == (m_val[k] % 256));
        else                   ok = (a >= m_val[0]) && (a <= m_val[1]);
        if (m_pge[k] != 0 && p != m_pg[k]) ok = 0;
        return ok;
    endfunction

    function automatic bit m_dhit(int d);
        if (m_bs[1] == 1) return (d / 256) == (m_val[1] / 256);
        if (m_bs[1] == 2) return (d % 256) == (m_val[1] % 256);
        return d == m_val[1];
    endfunction

    function automatic bit m_rwok(int k, int rd);
        return (m_rwe[k] == 0) || (rd == m_rw[k]);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_en = 0; m_full = 0; m_tag = 0; m_act = 0; m_pend = 0;
            for (int k = 0; k < 2; k++) begin
                m_bs[k] = 0; m_rwe[k] = 0; m_rw[k] = 0; m_pge[k] = 0; m_val[k] = 0; m_pg[k] = 0;
            end
            e_dbg = 0; e_swi = 0;
        end else begin
            bit fh, th, blk, ff, ft;
            int a, p, d, rd;
            a = int'(bus_addr); p = int'(bus_page); d = int'(bus_data); rd = int'(bus_rd);
            if (m_full != 0) begin
                fh = bus_valid && m_ahit(0, a, p) && m_rwok(0, rd) && m_dhit(d);
                th = tag_exec && m_ahit(0, int'(tag_addr), int'(tag_page));
            end else begin
                fh = bus_valid && ((m_ahit(0, a, p) && m_rwok(0, rd)) ||
                                   (m_ahit(1, a, p) && m_rwok(1, rd)));
                th = tag_exec && (m_ahit(0, int'(tag_addr), int'(tag_page)) ||
                                  m_ahit(1, int'(tag_addr), int'(tag_page)));
            end
            blk = (m_en == 0) || dbg_active;
            ff = !blk && (m_tag == 0) && insn_bnd && ((m_pend != 0) || fh);
            ft = !blk && (m_tag != 0) && th;
            e_dbg = (m_act != 0) && (ff || (ft && !trace_active));
            e_swi = (m_act == 0) && (ff || ft);
            if (blk || m_tag != 0 || ff) m_pend = 0;
            else if (fh)                 m_pend = 1;
            if (wr_en) begin
                int w; w = int'(wr_data);
                case (wr_sel)
                    3'd0: begin m_en = w % 2; m_full = (w / 2) % 2; m_tag = (w / 4) % 2; m_act = (w / 8) % 2; end
                    3'd1, 3'd2: begin
                        int k; k = int'(wr_sel) - 1;
                        m_bs[k] = w % 4; m_rwe[k] = (w / 4) % 2; m_rw[k] = (w / 8) % 2; m_pge[k] = (w / 16) % 2;
                    end
                    3'd3: m_val[0] = w;
                    3'd5: m_val[1] = w;
                    3'd4: m_pg[0] = w % 256;
                    3'd6: m_pg[1] = w % 256;
                    default: ;
                endcase
            end
        end
    end

    always @(negedge clk) begin
        if (checking) begin
            n_tests++;
            if (dbg_req !== e_dbg || swi_req !== e_swi) begin
                n_fail++;
                $display("FAIL %s: dbg/swi actual %b%b expected %b%b at %0t",
                         phase, dbg_req, swi_req, e_dbg, e_swi, $time);
            end
            if (dbg_req === 1'b1) cnt_dbg++;
            if (swi_req === 1'b1) cnt_swi++;
        end
    end

    task automatic mark(string ph);
        phase = ph; cnt_dbg = 0; cnt_swi = 0;
    endtask

    task automatic check_cnt(int ed, int es);
        n_tests++;
        if (cnt_dbg != ed || cnt_swi != es) begin
            n_fail++;
            $display("FAIL %s: pulse counts dbg/swi actual %0d/%0d expected %0d/%0d",
                     phase, cnt_dbg, cnt_swi, ed, es);
        end
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(int sel, int data);
        wr_en = 1; wr_sel = 3'(sel); wr_data = 16'(data);
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic bus(int a, int p, int d, int rd);
        bus_valid = 1; bus_addr = 16'(a); bus_page = 8'(p); bus_data = 16'(d); bus_rd = rd[0];
        @(negedge clk);
        bus_valid = 0;
    endtask

    task automatic bnd();
        insn_bnd = 1;
        @(negedge clk);
        insn_bnd = 0;
    endtask

    task automatic hitb(int a, int p, int d, int rd);
        bus(a, p, d, rd); bnd(); idle(2);
    endtask

    task automatic tag(int a, int p);
        tag_exec = 1; tag_addr = 16'(a); tag_page = 8'(p);
        @(negedge clk);
        tag_exec = 0; idle(2);
    endtask

    initial begin
        #400000;
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog in %s: actual hang expected finish", phase);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1;
        checking = 1;
        // R1: quiet after reset and while disabled
        mark("R1");
        idle(2);
        wr(3, 16'h1234);
        hitb(16'h1234, 0, 0, 1);
        check_cnt(0, 0);

        // R2 / R3 / R11: dual forced, swi then dbg action
        mark("R3");
        wr(0, 4'h1); wr(5, 16'h4000);
        bus(16'h1234, 0, 0, 1); idle(1); bnd(); idle(2);
        hitb(16'h4000, 0, 0, 0);
        hitb(16'h5555, 0, 0, 1);
        wr(0, 4'h9);
        hitb(16'h4000, 0, 0, 1);
        check_cnt(1, 2);
        wr(0, 4'h1);

        // R4: byte selects and page check
        mark("R4");
        wr(1, 5'h01); hitb(16'h12ab, 0, 0, 1);
        wr(1, 5'h02); hitb(16'hff34, 0, 0, 1); hitb(16'hff35, 0, 0, 1);
        wr(1, 5'h10); wr(4, 3);
        hitb(16'h1234, 3, 0, 1); hitb(16'h1234, 2, 0, 1);
        check_cnt(0, 3);

        // R5: inclusive range
        mark("R5");
        wr(1, 5'h03); wr(3, 16'h1000); wr(5, 16'h2000);
        hitb(16'h0fff, 0, 0, 1); hitb(16'h1000, 0, 0, 1); hitb(16'h2000, 0, 0, 1);
        hitb(16'h2001, 0, 0, 1); hitb(16'h1800, 0, 0, 1);
        check_cnt(0, 3);

        // R6: read/write qualifier
        mark("R6");
        wr(3, 16'h1234); wr(5, 16'h4000); wr(1, 5'h0C);
        hitb(16'h1234, 0, 0, 0); hitb(16'h1234, 0, 0, 1);
        wr(1, 5'h04);
        hitb(16'h1234, 0, 0, 1); hitb(16'h1234, 0, 0, 0);
        check_cnt(0, 2);

        // R7: pending and boundary timing
        mark("R7");
        wr(1, 5'h00);
        bus_valid = 1; bus_addr = 16'h1234; bus_rd = 1; insn_bnd = 1;
        @(negedge clk); bus_valid = 0; insn_bnd = 0; idle(2);
        bus(16'h1234, 0, 0, 1); bus(16'h4000, 0, 0, 1); bnd(); idle(2);
        bnd(); idle(2);
        bus(16'h1234, 0, 0, 1); insn_bnd = 1; idle(2); insn_bnd = 0; idle(2);
        check_cnt(0, 3);

        // R8: tagged dual
        mark("R8");
        wr(0, 4'h5);
        hitb(16'h1234, 0, 0, 1);
        tag(16'h1234, 0); tag(16'h4000, 0); tag(16'h4444, 0);
        check_cnt(0, 2);

        // R9: full forced
        mark("R9");
        wr(0, 4'h3); wr(5, 16'hABCD); wr(2, 5'h0C);
        hitb(16'h1234, 0, 16'hABCD, 0);
        hitb(16'h1234, 0, 16'hAB00, 0);
        wr(2, 5'h01); hitb(16'h1234, 0, 16'hAB00, 1);
        wr(2, 5'h02); hitb(16'h1234, 0, 16'h00CD, 1);
        hitb(16'hABCD, 0, 16'hABCD, 1);
        check_cnt(0, 3);

        // R10: full tagged ignores data
        mark("R10");
        wr(0, 4'h7); bus_data = 16'h0000;
        tag(16'h1234, 0); tag(16'hABCD, 0);
        check_cnt(0, 1);

        // R12: debug active blocks and clears pending
        mark("R12");
        wr(0, 4'h9); wr(2, 5'h00); wr(5, 16'h4000);
        bus(16'h1234, 0, 0, 1); dbg_active = 1; idle(1); dbg_active = 0; bnd(); idle(2);
        dbg_active = 1; bus(16'h1234, 0, 0, 1); bnd(); dbg_active = 0; idle(2);
        bus(16'h1234, 0, 0, 1); dbg_active = 1; bnd(); dbg_active = 0; idle(2);
        check_cnt(0, 0);

        // R13: trace blocks tagged debug only
        mark("R13");
        trace_active = 1;
        wr(0, 4'hD); tag(16'h1234, 0);
        wr(0, 4'h5); tag(16'h1234, 0);
        wr(0, 4'h9); hitb(16'h1234, 0, 0, 1);
        trace_active = 0;
        check_cnt(1, 1);

        // R14: disable discards pending
        mark("R14");
        wr(0, 4'h1);
        bus(16'h1234, 0, 0, 1); wr(0, 4'h0); wr(0, 4'h1); bnd(); idle(2);
        check_cnt(0, 0);

        checking = 0;
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule